// File: doc/BRIEF.md
# Output Voltage Fault Monitor

This block watches the regulated output of a buck converter one sample at a time. Each sample is compared against four programmable limits: an over-voltage warning, an over-voltage fault, an under-voltage warning and an under-voltage fault. The matching warning and fault flags latch until software clears them. An over-voltage fault is declared only when a second over-limit reading arrives while a confirmation window, opened by the first reading, is still running. A lone reading is treated as a transient. A confirmed over-voltage fault produces a one-cycle pulse request and holds the enable that keeps the synchronous rectifier switched on, so that the output is discharged actively.

The block also drives the power-good pin. The pin uses on and off thresholds with hysteresis and a selectable polarity, and it drops whenever the output is being ramped down. When a fault is latched, the block records the two-bit response code programmed for that fault and turns it into a shutdown request for the power sequencer. The startup sequencer can mask over-voltage or under-voltage comparisons, for example while starting into a pre-biased output.

Top module: `vout_guard`

## Requirements
- R1: A sample whose code is strictly above `ov_warn_lim` sets `ov_warn`, and one strictly below `uv_warn_lim` sets `uv_warn`. A code equal to a limit sets nothing. The flags are visible in the cycle after the sampling clock edge.
- R2: A sample whose code is strictly below `uv_fault_lim` sets `uv_fault`.
- R3: A single sample strictly above `ov_fault_lim` does not set `ov_fault`. It only opens a confirmation window lasting `WIN_US` microsecond ticks.
- R4: A second over-limit sample that arrives after fewer than `WIN_US` ticks since the window opened sets `ov_fault` and closes the window. After `WIN_US` ticks the window has expired, and the next over-limit sample opens a new window without setting a fault.
- R5: On a confirmed over-voltage fault, `sr_pulse` is high for exactly one cycle, in the same cycle in which `ov_fault` first appears. `sr_latch_en` rises in that cycle and stays high until a clear.
- R6: `alert_req` is high while `ov_fault` or `uv_fault` is latched. A warning on its own never raises `alert_req`.
- R7: The response codes `ov_resp` and `uv_resp` are 2 bits wide. Code 00 means continue; any other value raises `shut_req`, which holds until a clear. `act_rec` holds the code of the fault that latched, and over-voltage takes priority when both faults latch in the same cycle. Both outputs return to 00 or 0 on a clear.
- R8: Flags hold until `clr_flags`. If a clear and a sample that meets a condition arrive in the same cycle, the flag for that condition stays set.
- R9: While `mask_ov` is high, samples neither set `ov_warn` nor open or confirm the over-voltage window. While `mask_uv` is high, samples set neither `uv_warn` nor `uv_fault`. Each mask leaves the other group of checks working.
- R10: The power-good state turns on when a sample is at or above `pg_on_lvl`, turns off when a sample is strictly below `pg_off_lvl`, and holds for samples in between. It is updated one cycle after the sample edge.
- R11: The power-good state is forced off in the cycle after `ramp_down` is high, or in the cycle after `shut_req` is high. It cannot turn on again while either of them is high.
- R12: If the low byte of `pg_pol` is zero, `pg_pin` is active-low. Any nonzero value makes it active-high.
- R13: After reset all flags, `alert_req`, `shut_req`, `sr_pulse` and `sr_latch_en` are 0, `act_rec` is 00, and the power-good state is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | New output-voltage sample strobe |
| smp_code | input | VW | Output-voltage sample code |
| ov_warn_lim | input | VW | Over-voltage warning limit |
| ov_fault_lim | input | VW | Over-voltage fault limit |
| uv_warn_lim | input | VW | Under-voltage warning limit |
| uv_fault_lim | input | VW | Under-voltage fault limit |
| pg_on_lvl | input | VW | Power-good turn-on level |
| pg_off_lvl | input | VW | Power-good turn-off level |
| pg_pol | input | 8 | Power-good polarity byte |
| ov_resp | input | 2 | Over-voltage fault response code |
| uv_resp | input | 2 | Under-voltage fault response code |
| us_tick | input | 1 | One-microsecond time base strobe |
| clr_flags | input | 1 | Clear latched flags and requests |
| mask_ov | input | 1 | Suppress over-voltage comparisons |
| mask_uv | input | 1 | Suppress under-voltage comparisons |
| ramp_down | input | 1 | Output is being ramped down |
| ov_warn | output | 1 | Over-voltage warning flag |
| ov_fault | output | 1 | Confirmed over-voltage fault flag |
| uv_warn | output | 1 | Under-voltage warning flag |
| uv_fault | output | 1 | Under-voltage fault flag |
| alert_req | output | 1 | Alert request to the host bus |
| shut_req | output | 1 | Shutdown request to the sequencer |
| sr_pulse | output | 1 | One-cycle short-pulse request |
| sr_latch_en | output | 1 | Hold synchronous rectifier on |
| act_rec | output | 2 | Recorded response code |
| pg_pin | output | 1 | Power-good pin level |

## Verification
Flags, `alert_req`, `shut_req`, `act_rec`, `sr_pulse` and `sr_latch_en` change on the clock edge that takes in the sample or clear, so the bench reads them at the falling edge that follows. The power-good state also settles one edge after a sample. A drop caused by `shut_req` needs one edge more, because it acts only after `shut_req` has been registered, and the bench checks power-good as still on in the first cycle and off in the second. Window expiry is measured in `us_tick` pulses delivered in cycles without a sample, so the 99-tick and 100-tick cases fall exactly on either side of the limit.

// File: rtl/vout_guard_pkg.sv
package vout_guard_pkg;

    localparam int NFLAG   = 4;
    localparam int IDX_OVW = 0;
    localparam int IDX_OVF = 1;
    localparam int IDX_UVW = 2;
    localparam int IDX_UVF = 3;

    typedef enum logic [1:0] {
        RSP_CONTINUE   = 2'b00,
        RSP_STOP       = 2'b01,
        RSP_STOP_RETRY = 2'b10,
        RSP_STOP_HOLD  = 2'b11
    } resp_e;

    // Qualified comparison results for one sample.
    typedef struct packed {
        logic ov_warn;
        logic ov_read;
        logic uv_warn;
        logic uv_fault;
    } cmp_hits_t;

    function automatic logic resp_stops(input logic [1:0] code);
        return resp_e'(code) != RSP_CONTINUE;
    endfunction

endpackage

// File: rtl/vg_limit_cmp.sv
module vg_limit_cmp
    import vout_guard_pkg::*;
#(
    parameter int VW = 12
) (
    input  logic          smp_vld,
    input  logic [VW-1:0] smp_code,
    input  logic [VW-1:0] ov_warn_lim,
    input  logic [VW-1:0] ov_fault_lim,
    input  logic [VW-1:0] uv_warn_lim,
    input  logic [VW-1:0] uv_fault_lim,
    input  logic          mask_ov,
    input  logic          mask_uv,
    output cmp_hits_t     hits
);

    logic ov_en;
    logic uv_en;

    assign ov_en = smp_vld && !mask_ov;
    assign uv_en = smp_vld && !mask_uv;

    always_comb begin
        hits          = '0;
        hits.ov_warn  = ov_en && (smp_code > ov_warn_lim);
        hits.ov_read  = ov_en && (smp_code > ov_fault_lim);
        hits.uv_warn  = uv_en && (smp_code < uv_warn_lim);
        hits.uv_fault = uv_en && (smp_code < uv_fault_lim);
    end

endmodule

// File: rtl/vg_ov_confirm.sv
module vg_ov_confirm #(
    parameter int WIN_US = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic ov_read,
    input  logic us_tick,
    output logic confirm
);

    localparam int CW = $clog2(WIN_US + 1);

    logic [CW-1:0] cnt;
    logic          armed;

    assign armed   = (cnt != '0);
    assign confirm = ov_read && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ov_read) begin
            cnt <= armed ? '0 : CW'(WIN_US);
        end else if (us_tick && armed) begin
            cnt <= cnt - 1'b1;
        end
    end

    assert_window_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(WIN_US));

    assert_confirm_closes_R4: assert property (@(posedge clk) disable iff (rst)
        confirm |=> (cnt == '0));

    assert_arm_loads_R3: assert property (@(posedge clk) disable iff (rst)
        (ov_read && !armed) |=> (cnt == CW'(WIN_US)));

endmodule

// File: rtl/vg_flag_bank.sv
module vg_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_o[i] <= 1'b0;
            end else begin
                flags_o[i] <= (flags_o[i] && !clr_i) || set_i[i];
            end
        end
    end

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_i && (set_i == '0)) |=> (flags_o == '0));

    assert_set_sticks_R8: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/vg_pgood.sv
module vg_pgood #(
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_vld,
    input  logic [VW-1:0] smp_code,
    input  logic [VW-1:0] pg_on_lvl,
    input  logic [VW-1:0] pg_off_lvl,
    input  logic          force_off,
    input  logic [7:0]    pg_pol,
    output logic          pg_state,
    output logic          pg_pin
);

    logic go_on;
    logic go_off;
    logic act_high;

    assign go_on    = smp_vld && (smp_code >= pg_on_lvl);
    assign go_off   = smp_vld && (smp_code < pg_off_lvl);
    assign act_high = (pg_pol != 8'h00);

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_state <= 1'b0;
        end else if (force_off || go_off) begin
            pg_state <= 1'b0;
        end else if (go_on) begin
            pg_state <= 1'b1;
        end
    end

    assign pg_pin = act_high ? pg_state : !pg_state;

    assert_forced_off_R11: assert property (@(posedge clk) disable iff (rst)
        force_off |=> !pg_state);

    assert_rise_needs_on_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_state) |-> $past(go_on));

endmodule

// File: rtl/vout_guard.sv
module vout_guard
    import vout_guard_pkg::*;
#(
    parameter int VW     = 12,
    parameter int WIN_US = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_vld,
    input  logic [VW-1:0] smp_code,
    input  logic [VW-1:0] ov_warn_lim,
    input  logic [VW-1:0] ov_fault_lim,
    input  logic [VW-1:0] uv_warn_lim,
    input  logic [VW-1:0] uv_fault_lim,
    input  logic [VW-1:0] pg_on_lvl,
    input  logic [VW-1:0] pg_off_lvl,
    input  logic [7:0]    pg_pol,
    input  logic [1:0]    ov_resp,
    input  logic [1:0]    uv_resp,
    input  logic          us_tick,
    input  logic          clr_flags,
    input  logic          mask_ov,
    input  logic          mask_uv,
    input  logic          ramp_down,
    output logic          ov_warn,
    output logic          ov_fault,
    output logic          uv_warn,
    output logic          uv_fault,
    output logic          alert_req,
    output logic          shut_req,
    output logic          sr_pulse,
    output logic          sr_latch_en,
    output logic [1:0]    act_rec,
    output logic          pg_pin
);

    cmp_hits_t        hits;
    logic             ov_confirm;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flags;
    logic             stop_now;
    logic             pg_state;

    vg_limit_cmp #(.VW(VW)) i_cmp (
        .smp_vld      (smp_vld),
        .smp_code     (smp_code),
        .ov_warn_lim  (ov_warn_lim),
        .ov_fault_lim (ov_fault_lim),
        .uv_warn_lim  (uv_warn_lim),
        .uv_fault_lim (uv_fault_lim),
        .mask_ov      (mask_ov),
        .mask_uv      (mask_uv),
        .hits         (hits)
    );

    vg_ov_confirm #(.WIN_US(WIN_US)) i_win (
        .clk     (clk),
        .rst     (rst),
        .ov_read (hits.ov_read),
        .us_tick (us_tick),
        .confirm (ov_confirm)
    );

    always_comb begin
        flag_set          = '0;
        flag_set[IDX_OVW] = hits.ov_warn;
        flag_set[IDX_OVF] = ov_confirm;
        flag_set[IDX_UVW] = hits.uv_warn;
        flag_set[IDX_UVF] = hits.uv_fault;
    end

    vg_flag_bank #(.N(NFLAG)) i_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (flag_set),
        .clr_i   (clr_flags),
        .flags_o (flags)
    );

    assign ov_warn  = flags[IDX_OVW];
    assign ov_fault = flags[IDX_OVF];
    assign uv_warn  = flags[IDX_UVW];
    assign uv_fault = flags[IDX_UVF];

    // Only faults reach the host alert; warnings stay silent.
    assign alert_req = ov_fault || uv_fault;

    assign stop_now = (ov_confirm && resp_stops(ov_resp)) ||
                      (hits.uv_fault && resp_stops(uv_resp));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_rec     <= RSP_CONTINUE;
            shut_req    <= 1'b0;
            sr_pulse    <= 1'b0;
            sr_latch_en <= 1'b0;
        end else begin
            sr_pulse    <= ov_confirm;
            sr_latch_en <= (sr_latch_en && !clr_flags) || ov_confirm;
            shut_req    <= (shut_req && !clr_flags) || stop_now;
            if (ov_confirm) begin
                act_rec <= ov_resp;
            end else if (hits.uv_fault) begin
                act_rec <= uv_resp;
            end else if (clr_flags) begin
                act_rec <= RSP_CONTINUE;
            end
        end
    end

    vg_pgood #(.VW(VW)) i_pg (
        .clk        (clk),
        .rst        (rst),
        .smp_vld    (smp_vld),
        .smp_code   (smp_code),
        .pg_on_lvl  (pg_on_lvl),
        .pg_off_lvl (pg_off_lvl),
        .force_off  (ramp_down || shut_req),
        .pg_pol     (pg_pol),
        .pg_state   (pg_state),
        .pg_pin     (pg_pin)
    );

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        sr_pulse |=> !sr_pulse);

    assert_pulse_with_latch_R5: assert property (@(posedge clk) disable iff (rst)
        sr_pulse |-> (sr_latch_en && ov_fault));

    assert_uv_fault_alerts_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(uv_fault) |-> alert_req);

    assert_shut_has_fault_R7: assert property (@(posedge clk) disable iff (rst)
        shut_req |-> (ov_fault || uv_fault));

    assert_shut_drops_pg_R11: assert property (@(posedge clk) disable iff (rst)
        shut_req |=> !pg_state);

endmodule

// File: tb/test_vout_guard.sv
module test_vout_guard;

    localparam int VW = 12;
    localparam int WIN_US = 100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_vld = 1'b0;
    logic [VW-1:0] smp_code = '0;
    logic [VW-1:0] ov_warn_lim = 12'd2800;
    logic [VW-1:0] ov_fault_lim = 12'd3000;
    logic [VW-1:0] uv_warn_lim = 12'd1800;
    logic [VW-1:0] uv_fault_lim = 12'd1600;
    logic [VW-1:0] pg_on_lvl = 12'd1900;
    logic [VW-1:0] pg_off_lvl = 12'd1700;
    logic [7:0]    pg_pol = 8'h00;
    logic [1:0]    ov_resp = 2'b00;
    logic [1:0]    uv_resp = 2'b00;
    logic          us_tick = 1'b0;
    logic          clr_flags = 1'b0;
    logic          mask_ov = 1'b0;
    logic          mask_uv = 1'b0;
    logic          ramp_down = 1'b0;
    logic ov_warn, ov_fault, uv_warn, uv_fault, alert_req, shut_req;
    logic sr_pulse, sr_latch_en, pg_pin;
    logic [1:0] act_rec;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    vout_guard #(.VW(VW), .WIN_US(WIN_US)) i_vout_guard (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_code(smp_code),
        .ov_warn_lim(ov_warn_lim), .ov_fault_lim(ov_fault_lim),
        .uv_warn_lim(uv_warn_lim), .uv_fault_lim(uv_fault_lim),
        .pg_on_lvl(pg_on_lvl), .pg_off_lvl(pg_off_lvl), .pg_pol(pg_pol),
        .ov_resp(ov_resp), .uv_resp(uv_resp), .us_tick(us_tick),
        .clr_flags(clr_flags), .mask_ov(mask_ov), .mask_uv(mask_uv),
        .ramp_down(ramp_down), .ov_warn(ov_warn), .ov_fault(ov_fault),
        .uv_warn(uv_warn), .uv_fault(uv_fault), .alert_req(alert_req),
        .shut_req(shut_req), .sr_pulse(sr_pulse), .sr_latch_en(sr_latch_en),
        .act_rec(act_rec), .pg_pin(pg_pin)
    );

    // {code, mask_ov, mask_uv, clear_first, expected {ov_warn, uv_warn, uv_fault, alert_req}}
    typedef struct packed {
        logic [11:0] code;
        logic        m_ov;
        logic        m_uv;
        logic        clr;
        logic [3:0]  exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{12'd2000, 1'b0, 1'b0, 1'b1, 4'b0000},  // R1 in band
        '{12'd2900, 1'b0, 1'b0, 1'b1, 4'b1000},  // R1 over warn
        '{12'd1700, 1'b0, 1'b0, 1'b1, 4'b0100},  // R1 R6 under warn, no alert
        '{12'd1500, 1'b0, 1'b0, 1'b1, 4'b0111},  // R2 R6 under fault
        '{12'd1500, 1'b0, 1'b1, 1'b1, 4'b0000},  // R9 uv masked
        '{12'd2900, 1'b1, 1'b0, 1'b1, 4'b0000},  // R9 ov masked
        '{12'd1500, 1'b1, 1'b0, 1'b1, 4'b0111},  // R9 ov mask leaves uv
        '{12'd2000, 1'b0, 1'b0, 1'b0, 4'b0111},  // R8 latched without clear
        '{12'd2000, 1'b0, 1'b0, 1'b1, 4'b0000},  // R8 cleared
        '{12'd1800, 1'b0, 1'b0, 1'b1, 4'b0000},  // R1 equal uv warn limit
        '{12'd2800, 1'b0, 1'b0, 1'b1, 4'b0000},  // R1 equal ov warn limit
        '{12'd1799, 1'b0, 1'b0, 1'b1, 4'b0100}   // R1 one below uv warn
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic sample(input logic [11:0] code);
        @(negedge clk);
        smp_vld  = 1'b1;
        smp_code = code;
        @(negedge clk);
        smp_vld  = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        check("R13 flags", {ov_warn, ov_fault, uv_warn, uv_fault}, 4'b0000);
        check("R13 requests", {alert_req, shut_req, sr_pulse, sr_latch_en}, 4'b0000);
        check("R13 act_rec", act_rec, 2'b00);
        check("R13 pg_pin active-low off", pg_pin, 1'b1);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].clr) clear();
            mask_ov = VECS[i].m_ov;
            mask_uv = VECS[i].m_uv;
            sample(VECS[i].code);
            mask_ov = 1'b0;
            mask_uv = 1'b0;
            check($sformatf("R1/R2/R6/R8/R9 vector %0d", i),
                  {ov_warn, uv_warn, uv_fault, alert_req}, VECS[i].exp);
        end

        clear();
        check("R8 clear", {ov_warn, ov_fault, uv_warn, uv_fault}, 4'b0000);

        // R8 clear and matching sample in the same cycle
        @(negedge clk);
        clr_flags = 1'b1; smp_vld = 1'b1; smp_code = 12'd1500;
        @(negedge clk);
        clr_flags = 1'b0; smp_vld = 1'b0;
        check("R8 re-latch", uv_fault, 1'b1);
        clear();

        // R3 R4 R5 R6 R7 confirmation
        ov_resp = 2'b10;
        sample(12'd3100);
        check("R3 single reading", {ov_fault, sr_pulse}, 2'b00);
        ticks(10);
        sample(12'd3100);
        check("R4 confirmed", ov_fault, 1'b1);
        check("R5 pulse and latch", {sr_pulse, sr_latch_en}, 2'b11);
        check("R6 alert on ov fault", alert_req, 1'b1);
        check("R7 shut and record", {shut_req, act_rec}, 3'b110);
        @(negedge clk);
        check("R5 pulse one cycle", {sr_pulse, sr_latch_en}, 2'b01);
        clear();
        check("R5 R7 cleared", {sr_latch_en, shut_req, act_rec}, 4'b0000);

        // R4 window expiry and edge
        sample(12'd3100);
        ticks(WIN_US);
        sample(12'd3100);
        check("R4 expired window", ov_fault, 1'b0);
        ticks(WIN_US - 1);
        sample(12'd3100);
        check("R4 last tick inside window", ov_fault, 1'b1);
        clear();

        // R7 under-voltage response
        ov_resp = 2'b00;
        uv_resp = 2'b01;
        sample(12'd1500);
        check("R7 uv shutdown", {uv_fault, alert_req, shut_req, act_rec}, 5'b11101);
        clear();
        uv_resp = 2'b00;

        // R9 masked over-voltage readings do not arm
        mask_ov = 1'b1;
        sample(12'd3100);
        sample(12'd3100);
        check("R9 masked ov", {ov_warn, ov_fault}, 2'b00);
        mask_ov = 1'b0;
        sample(12'd3100);
        check("R9 masked reads left window closed", ov_fault, 1'b0);
        ticks(WIN_US);
        clear();

        // R10 R11 R12 power good
        sample(12'd2000);
        check("R10 R12 on, active-low", pg_pin, 1'b0);
        pg_pol = 8'h01;
        #0;
        check("R12 active-high", pg_pin, 1'b1);
        sample(12'd1800);
        check("R10 hold between levels", pg_pin, 1'b1);
        sample(12'd1699);
        check("R10 off below off level", pg_pin, 1'b0);
        sample(12'd1900);
        check("R10 on at on level", pg_pin, 1'b1);
        @(negedge clk);
        ramp_down = 1'b1;
        @(negedge clk);
        ramp_down = 1'b0;
        check("R11 ramp down drops pg", pg_pin, 1'b0);
        sample(12'd2000);
        check("R10 back on", pg_pin, 1'b1);
        ov_resp = 2'b01;
        sample(12'd3100);
        sample(12'd3100);
        check("R11 shut_req set, pg not yet dropped", {shut_req, pg_pin}, 2'b11);
        @(negedge clk);
        check("R11 pg dropped after shut_req", pg_pin, 1'b0);
        sample(12'd2000);
        check("R11 held off while shut_req", pg_pin, 1'b0);
        clear();
        ov_resp = 2'b00;
        sample(12'd2000);
        check("R11 on after clear", pg_pin, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule